// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block keeps the pending, in-service and trigger-mode state of one interrupt controller, each as a 256-bit bitmap indexed by vector number. It also holds a task-priority value. From these it works out the processor priority and decides whether a pending vector may be delivered to the core.

Sources post vectors through a single accept strobe, and the block reports in the same cycle whether the request set a fresh pending bit or merged into one already pending. The core sees `has_intr`. It takes the winning vector through an acknowledge strobe, which moves that vector from pending to in-service. It signals completion through an end-of-interrupt strobe, which retires the highest in-service vector. One cycle later the block reports the retired vector and whether it was level- or edge-triggered, so that the interrupt source can be notified.

Priority works in classes of 16 vectors, where a class is the upper nibble of the vector. The task priority is written as a 4-bit class.

Top module: `vec_prio_ctrl`

## Requirements
- R1: After reset, nothing is pending or in service, the task priority and processor priority read 0, and `has_intr` and `eoi_done` are low.
- R2: An accept of a vector of 16 or above sets that vector's pending bit. In the same cycle, `acc_fresh` is 1 if the bit was clear and 0 if the bit was already set (coalesced). Vectors 0 to 15 are ignored: `acc_fresh` is 0 and nothing becomes pending.
- R3: Each accept records the trigger mode of its vector (level = 1, edge = 0), and the most recent accept wins. That recorded mode is reported on `eoi_level` when the vector is retired.
- R4: `ack_vector` is the highest-numbered pending vector, found by scanning from 255 downward.
- R5: `has_intr` is 1 exactly when some vector is pending and (highest pending vector AND 0xF0) > processor priority.
- R6: The processor priority is the task priority when task class ≥ class of the highest in-service vector; otherwise it is that vector with its low nibble cleared. An empty in-service set counts as vector 0. It is registered and settles one cycle after its inputs change. While it is unsettled, `has_intr` is held low.
- R7: `ack_req` while `has_intr` is high raises `ack_grant` in that cycle. At the clock edge, the winning vector leaves the pending set and enters the in-service set.
- R8: An `eoi` pulse clears the highest in-service bit. On the next cycle `eoi_done` pulses, with `eoi_vector` giving the retired vector. With nothing in service, `eoi` changes nothing and `eoi_done` stays low.
- R9: A task-priority write loads `{tpr_class, 4'b0000}` into the task priority on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Accept strobe |
| acc_vector | input | 8 | Vector being posted |
| acc_level | input | 1 | 1 = level trigger, 0 = edge |
| acc_fresh | output | 1 | Posted vector was not already pending |
| ack_req | input | 1 | Core acknowledge request |
| ack_grant | output | 1 | Acknowledge taken this cycle |
| ack_vector | output | 8 | Highest pending vector |
| eoi | input | 1 | End-of-interrupt strobe |
| eoi_done | output | 1 | A vector was retired last cycle |
| eoi_vector | output | 8 | Vector retired |
| eoi_level | output | 1 | Trigger mode of the retired vector |
| tpr_wr | input | 1 | Task-priority write strobe |
| tpr_class | input | 4 | Task-priority class to write |
| tpr | output | 8 | Task priority |
| ppr | output | 8 | Processor priority |
| pending | output | 1 | Any vector pending |
| has_intr | output | 1 | Deliverable interrupt present |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:

- **Every legal vector through the full cycle.** Each vector from 16 to 255 is accepted, acknowledged and retired. A search that skips a word boundary or picks the lowest bit would return the wrong vector.
- **Class comparison at its boundary.** Every pair of task class and vector class is tried. A `>=` in place of `>` would deliver a vector of the same class as the task priority.
- **Nested interrupts.** A lower-class vector is blocked while a higher class is in service, and retirement comes out in descending order. A stale processor priority, or an end-of-interrupt that retires the wrong bit, would deliver too early or report the wrong vector.
- **Coalesced requests and empty end-of-interrupt.** Re-posting a pending vector must show as coalesced, with the last trigger mode winning. An end-of-interrupt with nothing in service must produce no retire pulse.

// File: rtl/vec_prio_ctrl.sv
module vec_prio_ctrl #(
  parameter int NVEC   = 256,
  parameter int WORD   = 32,
  parameter int MINVEC = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc_valid,
  input  logic [$clog2(NVEC)-1:0]  acc_vector,
  input  logic                     acc_level,
  output logic                     acc_fresh,
  input  logic                     ack_req,
  output logic                     ack_grant,
  output logic [$clog2(NVEC)-1:0]  ack_vector,
  input  logic                     eoi,
  output logic                     eoi_done,
  output logic [$clog2(NVEC)-1:0]  eoi_vector,
  output logic                     eoi_level,
  input  logic                     tpr_wr,
  input  logic [3:0]               tpr_class,
  output logic [$clog2(NVEC)-1:0]  tpr,
  output logic [$clog2(NVEC)-1:0]  ppr,
  output logic                     pending,
  output logic                     has_intr
);
  localparam int VW    = $clog2(NVEC);
  localparam int CW    = 4;
  localparam int LW    = VW - CW;
  localparam int NWORD = NVEC / WORD;

  logic [NVEC-1:0] irr_q, isr_q, tmr_q;
  logic [NVEC-1:0] irr_n, isr_n, tmr_n;
  logic [VW-1:0]   tpr_q, ppr_q, ppr_nxt;
  logic            eoi_done_q, eoi_level_q;
  logic [VW-1:0]   eoi_vec_q;

  function automatic logic [VW:0] hi_find(input logic [NVEC-1:0] m);
    logic [VW:0]     r;
    logic [WORD-1:0] seg;
    r = '0;
    for (int w = 0; w < NWORD; w++) begin
      seg = m[w*WORD +: WORD];
      if (|seg)
        for (int b = 0; b < WORD; b++)
          if (seg[b]) r = {1'b1, VW'(w*WORD + b)};
    end
    return r;
  endfunction

  logic [VW:0]   irr_top, isr_top;
  logic          irr_hit, isr_hit;
  logic [VW-1:0] irr_idx, isr_idx, isrv;
  logic          acc_ok;

  assign irr_top = hi_find(irr_q);
  assign isr_top = hi_find(isr_q);
  assign irr_hit = irr_top[VW];
  assign irr_idx = irr_top[VW-1:0];
  assign isr_hit = isr_top[VW];
  assign isr_idx = isr_top[VW-1:0];
  assign isrv    = isr_hit ? isr_idx : '0;

  assign ppr_nxt = (tpr_q[VW-1:LW] >= isrv[VW-1:LW]) ? tpr_q
                                                     : {isrv[VW-1:LW], {LW{1'b0}}};

  assign acc_ok     = acc_valid && (acc_vector >= VW'(MINVEC));
  assign acc_fresh  = acc_ok && !irr_q[acc_vector];
  assign pending    = irr_hit;
  assign has_intr   = irr_hit && ({irr_idx[VW-1:LW], {LW{1'b0}}} > ppr_q)
                      && (ppr_q == ppr_nxt);
  assign ack_grant  = ack_req && has_intr;
  assign ack_vector = irr_idx;
  assign tpr        = tpr_q;
  assign ppr        = ppr_q;
  assign eoi_done   = eoi_done_q;
  assign eoi_vector = eoi_vec_q;
  assign eoi_level  = eoi_level_q;

  always_comb begin
    irr_n = irr_q;
    isr_n = isr_q;
    tmr_n = tmr_q;
    if (ack_grant) begin
      irr_n[irr_idx] = 1'b0;
      isr_n[irr_idx] = 1'b1;
    end
    if (eoi && isr_hit) isr_n[isr_idx] = 1'b0;
    if (acc_ok) begin
      irr_n[acc_vector] = 1'b1;
      tmr_n[acc_vector] = acc_level;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q       <= '0;
      isr_q       <= '0;
      tmr_q       <= '0;
      tpr_q       <= '0;
      ppr_q       <= '0;
      eoi_done_q  <= 1'b0;
      eoi_vec_q   <= '0;
      eoi_level_q <= 1'b0;
    end else begin
      irr_q       <= irr_n;
      isr_q       <= isr_n;
      tmr_q       <= tmr_n;
      ppr_q       <= ppr_nxt;
      if (tpr_wr) tpr_q <= {tpr_class, {LW{1'b0}}};
      eoi_done_q  <= eoi && isr_hit;
      if (eoi && isr_hit) begin
        eoi_vec_q   <= isr_idx;
        eoi_level_q <= tmr_q[isr_idx];
      end
    end
  end

  assert_fresh_pends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fresh |=> pending);
  assert_intr_needs_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    has_intr |-> pending);
  assert_ppr_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ppr_q == ppr_nxt) |-> (ppr >= tpr));
  assert_grant_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_grant |-> (ack_vector >= VW'(MINVEC)));
  assert_eoi_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !isr_hit) |=> !eoi_done);
  assert_tpr_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tpr_wr |=> (tpr == {$past(tpr_class), {LW{1'b0}}}));
endmodule

// File: tb/tb_vec_prio_ctrl.sv
module tb_vec_prio_ctrl;
  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_level = 0, ack_req = 0, eoi = 0, tpr_wr = 0;
  logic [7:0] acc_vector = 0;
  logic [3:0] tpr_class = 0;
  logic acc_fresh, ack_grant, eoi_done, eoi_level, pending, has_intr;
  logic [7:0] ack_vector, eoi_vector, tpr, ppr;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  vec_prio_ctrl dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic settle;
    tick; tick;
  endtask

  task automatic post(input int v, input bit lvl, input bit exp_fresh, input string tag);
    acc_valid = 1; acc_vector = 8'(v); acc_level = lvl; #1;
    chk(acc_fresh == exp_fresh, tag, acc_fresh, exp_fresh);
    tick;
    acc_valid = 0;
  endtask

  task automatic take(input int v);
    settle;
    ack_req = 1; #1;
    chk(ack_grant == 1, "R7 grant", ack_grant, 1);
    chk(ack_vector == 8'(v), "R4 winner", ack_vector, v);
    tick;
    ack_req = 0;
  endtask

  task automatic retire(input int v, input bit lvl);
    eoi = 1; tick; eoi = 0;
    chk(eoi_done == 1, "R8 done", eoi_done, 1);
    chk(eoi_vector == 8'(v), "R8 vector", eoi_vector, v);
    chk(eoi_level == lvl, "R3 level", eoi_level, lvl);
  endtask

  task automatic set_tpr(input int c);
    tpr_wr = 1; tpr_class = 4'(c); tick; tpr_wr = 0;
    chk(tpr == 8'(c << 4), "R9 tpr", tpr, c << 4);
    settle;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    chk(pending == 0, "R1 pending", pending, 0);
    chk(has_intr == 0, "R1 has_intr", has_intr, 0);
    chk(ppr == 0, "R1 ppr", ppr, 0);
    chk(tpr == 0, "R1 tpr", tpr, 0);
    chk(eoi_done == 0, "R1 eoi_done", eoi_done, 0);

    for (int v = 16; v < 256; v++) begin
      post(v, v[0], 1, "R2 fresh");
      post(v, v[0], 0, "R2 coalesced");
      settle;
      chk(has_intr == 1, "R5 deliverable", has_intr, 1);
      take(v);
      chk(pending == 0, "R7 irr cleared", pending, 0);
      settle;
      chk(ppr == (v & 8'hF0), "R6 ppr isr", ppr, v & 8'hF0);
      retire(v, v[0]);
      settle;
      chk(ppr == 0, "R6 ppr empty", ppr, 0);
    end

    for (int v = 0; v < 16; v++) begin
      post(v, 1, 0, "R2 low vector");
      chk(pending == 0, "R2 low ignored", pending, 0);
    end

    for (int t = 0; t < 16; t++)
      for (int c = 1; c < 16; c++) begin
        set_tpr(t);
        chk(ppr == 8'(t << 4), "R6 ppr tpr", ppr, t << 4);
        post(c * 16 + 5, 0, 1, "R2 fresh");
        settle;
        chk(has_intr == (c > t), "R5 class compare", has_intr, c > t);
        set_tpr(0);
        take(c * 16 + 5);
        retire(c * 16 + 5, 0);
      end

    post(40, 0, 1, "R2 fresh");
    post(200, 1, 1, "R2 fresh");
    post(100, 0, 1, "R2 fresh");
    take(200);
    settle;
    chk(ppr == 8'hC0, "R6 nested ppr", ppr, 8'hC0);
    chk(has_intr == 0, "R5 blocked by isr", has_intr, 0);
    post(230, 0, 1, "R2 fresh");
    take(230);
    retire(230, 0);
    settle;
    chk(has_intr == 0, "R5 still blocked", has_intr, 0);
    retire(200, 1);
    settle;
    chk(has_intr == 1, "R5 unblocked", has_intr, 1);
    take(100);
    retire(100, 0);
    eoi = 1; tick; eoi = 0;
    chk(eoi_done == 0, "R8 empty eoi", eoi_done, 0);
    chk(pending == 1, "R8 empty eoi no change", pending, 1);
    take(40);
    retire(40, 0);

    post(70, 1, 1, "R2 fresh");
    post(70, 0, 0, "R3 coalesced edge");
    take(70);
    retire(70, 0);

    post(8'h55, 0, 1, "R2 fresh");
    take(8'h55);
    set_tpr(9);
    chk(ppr == 8'h90, "R6 tpr above isr", ppr, 8'h90);
    set_tpr(3);
    chk(ppr == 8'h50, "R6 isr above tpr", ppr, 8'h50);
    set_tpr(5);
    chk(ppr == 8'h50, "R6 equal class", ppr, 8'h50);
    retire(8'h55, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule